// File: doc/BRIEF.md
# Framed Synchronous Serial Port

This block moves words of 1 to 16 bits between a parallel host side and a pair of serial data pins. A word begins one serial clock period after a frame sync is seen. The serial clock can be made on chip by dividing the master clock, or it can be taken from an input pin. The frame syncs can also be made on chip, from a counter of serial clock periods, or taken from input pins. Each frame sync has its own polarity setting.

The host writes three registers: the clock divider, the frame divider and a control word. It loads the word to send through a separate strobe and reads the last received word from a port that is always present. A one-cycle pulse marks the moment a transmit word is taken into the shifter. Another one-cycle pulse marks the moment a received word is complete.

All logic runs on the master clock `clk`. Serial clock edges become single-cycle strobes inside the block. Pins from outside pass through two synchronising flops before use.

Top module: `framed_serial_port`

## Requirements
- R1: Register address 0 holds the serial clock divider D. With the internal clock selected and the port enabled, `sclkOut` toggles every D+1 master clocks, so one serial period is 2×(D+1) clocks. Writing address 0 restarts the divider count.
- R2: Register address 1 holds the frame divider F. The internal frame sync becomes active at a rising serial edge once every F+1 rising edges and stays active for exactly one serial period. Writing address 1 restarts this count.
- R3: Register address 2 holds the control word. Bits 3:0 (L) give a word length of L+1 bits, from 1 to 16.
- R4: Control bit 5 inverts `rfsOut` and control bit 6 inverts `tfsOut`. With a bit clear the matching sync is active high. With it set the sync is active low. An inactive sync pin rests at the value of its invert bit.
- R5: `dtOut` changes only at rising serial edges and sends the most significant bit first. The first bit appears at the rising edge after the falling edge that saw the transmit sync active. Between words `dtOut` is low.
- R6: Control bit 4 enables the port. While it is clear, `sclkOut` stays low, no frame sync is made, `dtOut` is low and no interrupt pulse occurs.
- R7: `txIrq` is a one-cycle pulse in the cycle the transmit word is taken into the shifter. `rxIrq` is a one-cycle pulse in the cycle `rxData` is updated.
- R8: `drIn` is sampled at falling serial edges. Sampling starts at the falling edge after the one that saw the receive sync active. A completed word is placed right-justified in `rxData`, with the upper bits zero.
- R9: Control bits 7, 8 and 9 select an internal serial clock, an internal receive sync and an internal transmit sync when set. When clear, the block takes `sclkIn`, `rfsIn` and `tfsIn` through two-flop synchronisers. An external sync is first corrected by its invert bit.
- R10: After reset every register is zero. The port is therefore disabled, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 clock divider, 1 frame divider, 2 control |
| regWrData | input | 16 | Register write data |
| txWrEn | input | 1 | Load strobe for the transmit word |
| txData | input | 16 | Transmit word |
| rxData | output | 16 | Last received word, right-justified |
| txIrq | output | 1 | Pulse when the transmit word enters the shifter |
| rxIrq | output | 1 | Pulse when a received word completes |
| sclkIn | input | 1 | External serial clock |
| sclkOut | output | 1 | Internal serial clock |
| rfsIn | input | 1 | External receive frame sync |
| rfsOut | output | 1 | Internal receive frame sync |
| tfsIn | input | 1 | External transmit frame sync |
| tfsOut | output | 1 | Internal transmit frame sync |
| drIn | input | 1 | Serial receive data |
| dtOut | output | 1 | Serial transmit data |

## Verification
The serial clock output, the data output and both interrupt pulses come from registers. Each one changes at the master clock edge where the internal serial edge strobe is high. The frame sync pins follow the frame register with no added delay. The bench runs a behavioural model that advances at every rising clock edge and compares against it at the next falling edge, so each result is checked in the cycle it becomes due. External pin edges take three master clocks to act, so the external checks sample only at the end of each eight-clock half period.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int WORD_MAX = 16;
  localparam int LEN_W = $clog2(WORD_MAX);

  // Control word layout (LSB first): lenM1, enable, invRfs, invTfs, intSclk, intRfs, intTfs
  typedef struct packed {
    logic intTfs;
    logic intRfs;
    logic intSclk;
    logic invTfs;
    logic invRfs;
    logic enable;
    logic [LEN_W-1:0] lenM1;
  } fsp_ctrl_t;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic sclkRise;
    logic sclkFall;
    logic txStart;
    logic rxStart;
    logic clear;
  } fsp_strobe_t;
endpackage

// File: rtl/fsp_regs.sv
module fsp_regs
  import fsp_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wrData,
  output logic [DIV_W-1:0] sclkDiv,
  output logic [DIV_W-1:0] fsDiv,
  output fsp_ctrl_t        ctrl,
  output logic             sclkReload,
  output logic             fsReload
);
  localparam int CTRL_W = $bits(fsp_ctrl_t);

  logic unusedHigh;
  assign unusedHigh = ^wrData[REG_W-1:CTRL_W];

  assign sclkReload = wrEn && (addr == 2'd0);
  assign fsReload   = wrEn && (addr == 2'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkDiv <= '0;
      fsDiv   <= '0;
      ctrl    <= '0;
    end else if (wrEn) begin
      case (addr)
        2'd0:    sclkDiv <= wrData[DIV_W-1:0];
        2'd1:    fsDiv   <= wrData[DIV_W-1:0];
        2'd2:    ctrl    <= fsp_ctrl_t'(wrData[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  fsp_ctrl_t        ctrl,
  input  logic [DIV_W-1:0] sclkDiv,
  input  logic [DIV_W-1:0] fsDiv,
  input  logic             sclkReload,
  input  logic             fsReload,
  input  logic             sclkIn,
  input  logic             rfsIn,
  input  logic             tfsIn,
  output logic             sclkOut,
  output logic             rfsOut,
  output logic             tfsOut,
  output fsp_strobe_t      strb
);
  logic [DIV_W-1:0] divCnt, frameCnt;
  logic sclkLvl, fsPulse, txArm, rxArm;
  logic [2:0] sclkSync;
  logic [1:0] rfsSync, tfsSync;
  logic divHit, intRise, intFall, extRise, extFall, rise, fall, rfsAct, tfsAct;

  assign divHit  = divCnt == sclkDiv;
  assign intRise = ctrl.enable & ctrl.intSclk & ~sclkReload & divHit & ~sclkLvl;
  assign intFall = ctrl.enable & ctrl.intSclk & ~sclkReload & divHit & sclkLvl;
  assign extRise = ctrl.enable & sclkSync[1] & ~sclkSync[2];
  assign extFall = ctrl.enable & ~sclkSync[1] & sclkSync[2];
  assign rise    = ctrl.intSclk ? intRise : extRise;
  assign fall    = ctrl.intSclk ? intFall : extFall;
  assign rfsAct  = ctrl.intRfs ? fsPulse : (rfsSync[1] ^ ctrl.invRfs);
  assign tfsAct  = ctrl.intTfs ? fsPulse : (tfsSync[1] ^ ctrl.invTfs);

  // serial clock divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      sclkLvl <= 1'b0;
    end else if (!ctrl.enable || !ctrl.intSclk) begin
      divCnt  <= '0;
      sclkLvl <= 1'b0;
    end else if (sclkReload) begin
      divCnt <= '0;
    end else if (divHit) begin
      divCnt  <= '0;
      sclkLvl <= ~sclkLvl;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // external pin synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      rfsSync  <= '0;
      tfsSync  <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclkIn};
      rfsSync  <= {rfsSync[0], rfsIn};
      tfsSync  <= {tfsSync[0], tfsIn};
    end
  end

  // frame sync generator, counts rising serial edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
      fsPulse  <= 1'b0;
    end else if (!ctrl.enable || fsReload) begin
      frameCnt <= '0;
      fsPulse  <= 1'b0;
    end else if (rise) begin
      if (frameCnt == fsDiv) begin
        frameCnt <= '0;
        fsPulse  <= 1'b1;
      end else begin
        frameCnt <= frameCnt + DIV_W'(1);
        fsPulse  <= 1'b0;
      end
    end
  end

  // frame detection on falling edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txArm <= 1'b0;
      rxArm <= 1'b0;
    end else if (!ctrl.enable) begin
      txArm <= 1'b0;
      rxArm <= 1'b0;
    end else if (fall) begin
      txArm <= tfsAct;
      rxArm <= rfsAct;
    end
  end

  assign sclkOut = sclkLvl;
  assign rfsOut  = (ctrl.enable & ctrl.intRfs & fsPulse) ^ ctrl.invRfs;
  assign tfsOut  = (ctrl.enable & ctrl.intTfs & fsPulse) ^ ctrl.invTfs;

  assign strb.sclkRise = rise;
  assign strb.sclkFall = fall;
  assign strb.txStart  = rise & txArm;
  assign strb.rxStart  = fall & rxArm;
  assign strb.clear    = ~ctrl.enable;
endmodule

// File: rtl/fsp_datapath.sv
module fsp_datapath
  import fsp_pkg::*;
#(
  parameter int DATA_W = WORD_MAX
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsp_strobe_t       strb,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txData,
  input  logic              drIn,
  output logic              dtOut,
  output logic [DATA_W-1:0] rxData,
  output logic              txIrq,
  output logic              rxIrq
);
  localparam int CNT_W = LEN_W + 1;

  logic [DATA_W-1:0] txBuf, txSh, rxSh, rxShNext;
  logic [LEN_W-1:0]  txIdx, idxDown;
  logic [CNT_W-1:0]  rxCnt, rxCntNext;
  logic txBusy, rxBusy, rxStep, rxDone;

  assign idxDown = txIdx - LEN_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txBuf <= '0;
    else if (txWrEn) txBuf <= txData;
  end

  // transmit shifter, MSB first on rising edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      txIdx  <= '0;
      txBusy <= 1'b0;
      dtOut  <= 1'b0;
      txIrq  <= 1'b0;
    end else if (strb.clear) begin
      txBusy <= 1'b0;
      dtOut  <= 1'b0;
      txIrq  <= 1'b0;
    end else if (strb.txStart) begin
      txSh   <= txBuf;
      txIdx  <= lenM1;
      dtOut  <= txBuf[lenM1];
      txBusy <= lenM1 != '0;
      txIrq  <= 1'b1;
    end else begin
      txIrq <= 1'b0;
      if (strb.sclkRise) begin
        if (txBusy) begin
          dtOut  <= txSh[idxDown];
          txIdx  <= idxDown;
          txBusy <= idxDown != '0;
        end else begin
          dtOut <= 1'b0;
        end
      end
    end
  end

  // receive shifter, sampled on falling edges
  always_comb begin
    rxStep    = strb.rxStart | (strb.sclkFall & rxBusy);
    rxShNext  = strb.rxStart ? {{(DATA_W-1){1'b0}}, drIn} : {rxSh[DATA_W-2:0], drIn};
    rxCntNext = strb.rxStart ? CNT_W'(1) : rxCnt + CNT_W'(1);
    rxDone    = rxCntNext == ({1'b0, lenM1} + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh   <= '0;
      rxCnt  <= '0;
      rxBusy <= 1'b0;
      rxData <= '0;
      rxIrq  <= 1'b0;
    end else if (strb.clear) begin
      rxBusy <= 1'b0;
      rxIrq  <= 1'b0;
    end else begin
      rxIrq <= 1'b0;
      if (rxStep) begin
        rxSh  <= rxShNext;
        rxCnt <= rxCntNext;
        if (rxDone) begin
          rxData <= rxShNext;
          rxIrq  <= 1'b1;
          rxBusy <= 1'b0;
        end else begin
          rxBusy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/framed_serial_port.sv
module framed_serial_port
  import fsp_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int DIV_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [REG_W-1:0]    regWrData,
  input  logic                txWrEn,
  input  logic [WORD_MAX-1:0] txData,
  output logic [WORD_MAX-1:0] rxData,
  output logic                txIrq,
  output logic                rxIrq,
  input  logic                sclkIn,
  output logic                sclkOut,
  input  logic                rfsIn,
  output logic                rfsOut,
  input  logic                tfsIn,
  output logic                tfsOut,
  input  logic                drIn,
  output logic                dtOut
);
  logic [DIV_W-1:0] sclkDiv, fsDiv;
  logic sclkReload, fsReload;
  fsp_ctrl_t ctrlReg;
  fsp_strobe_t strb;

  fsp_regs #(.REG_W(REG_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .sclkDiv(sclkDiv), .fsDiv(fsDiv), .ctrl(ctrlReg),
    .sclkReload(sclkReload), .fsReload(fsReload)
  );

  fsp_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrl(ctrlReg), .sclkDiv(sclkDiv), .fsDiv(fsDiv),
    .sclkReload(sclkReload), .fsReload(fsReload),
    .sclkIn(sclkIn), .rfsIn(rfsIn), .tfsIn(tfsIn),
    .sclkOut(sclkOut), .rfsOut(rfsOut), .tfsOut(tfsOut), .strb(strb)
  );

  fsp_datapath #(.DATA_W(WORD_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lenM1(ctrlReg.lenM1),
    .txWrEn(txWrEn), .txData(txData), .drIn(drIn),
    .dtOut(dtOut), .rxData(rxData), .txIrq(txIrq), .rxIrq(rxIrq)
  );
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        en,
  input logic        fallStb,
  input logic        sclkOut,
  input logic        dtOut,
  input logic        txIrq,
  input logic        rxIrq,
  input logic [3:0]  lenM1,
  input logic [15:0] rxData
);
  p_tx_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);

  p_rx_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!sclkOut && !dtOut && !txIrq && !rxIrq));

  p_dt_on_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (en && fallStb) |=> $stable(dtOut));

  p_zero_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> ((32'(rxData) >> (32'(lenM1) + 1)) == 32'd0));
endmodule

bind framed_serial_port fsp_checker u_chk (
  .clk(clk), .rstN(rstN), .en(ctrlReg.enable), .fallStb(strb.sclkFall),
  .sclkOut(sclkOut), .dtOut(dtOut), .txIrq(txIrq), .rxIrq(rxIrq),
  .lenM1(ctrlReg.lenM1), .rxData(rxData)
);

// File: tb/framed_serial_port_tb.sv
`timescale 1ns/1ps
module framed_serial_port_tb;
  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0;
  logic [1:0] regAddr = 0;
  logic [15:0] regWrData = 0;
  logic txWrEn = 0;
  logic [15:0] txData = 0;
  logic [15:0] rxData;
  logic txIrq, rxIrq, sclkOut, rfsOut, tfsOut, dtOut, drIn;
  logic sclkIn = 0, rfsIn = 0, tfsIn = 0, extDr = 0, useLoop = 1;
  int checks = 0, errors = 0;
  bit modelOn = 0, done = 0;
  int irqSeen = 0;

  always #2.5 clk = ~clk;
  assign drIn = useLoop ? dtOut : extDr;

  framed_serial_port u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .txWrEn(txWrEn), .txData(txData), .rxData(rxData), .txIrq(txIrq), .rxIrq(rxIrq),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .rfsIn(rfsIn), .rfsOut(rfsOut),
    .tfsIn(tfsIn), .tfsOut(tfsOut), .drIn(drIn), .dtOut(dtOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, internal clock and syncs only
  int mDiv, mFsd, mCtrl, mCnt, mLvl, mFc, mFs, mTxArm, mRxArm;
  int mTxBuf, mTxSh, mTxIdx, mTxBusy, mDt, mTxIrq;
  int mRxSh, mRxCnt, mRxBusy, mRxData, mRxIrq;
  int mLen, mEn, rise, fall, oldDt, oldFs, txGo, rxGo;

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mFsd = 0; mCtrl = 0; mCnt = 0; mLvl = 0; mFc = 0; mFs = 0;
      mTxArm = 0; mRxArm = 0; mTxBuf = 0; mTxSh = 0; mTxIdx = 0; mTxBusy = 0;
      mDt = 0; mTxIrq = 0; mRxSh = 0; mRxCnt = 0; mRxBusy = 0; mRxData = 0; mRxIrq = 0;
    end else begin
      mLen = (mCtrl & 15) + 1;
      mEn = (mCtrl >> 4) & 1;
      rise = 0; fall = 0; oldDt = mDt; oldFs = mFs;
      if (mEn != 0) begin
        if (regWrEn && regAddr == 0) mCnt = 0;
        else if (mCnt == mDiv) begin
          mCnt = 0;
          if (mLvl == 0) rise = 1; else fall = 1;
          mLvl = 1 - mLvl;
        end else mCnt++;
      end else begin mCnt = 0; mLvl = 0; end
      txGo = rise & mTxArm;
      rxGo = fall & mRxArm;
      if (mEn == 0 || (regWrEn && regAddr == 1)) begin mFc = 0; mFs = 0; end
      else if (rise != 0) begin
        if (mFc == mFsd) begin mFc = 0; mFs = 1; end else begin mFc++; mFs = 0; end
      end
      if (mEn == 0) begin mTxArm = 0; mRxArm = 0; end
      else if (fall != 0) begin mTxArm = oldFs; mRxArm = oldFs; end
      mTxIrq = 0; mRxIrq = 0;
      if (mEn == 0) begin mDt = 0; mTxBusy = 0; mRxBusy = 0; end
      else begin
        if (txGo != 0) begin
          mTxSh = mTxBuf; mTxIdx = mLen - 1; mDt = (mTxBuf >> (mLen - 1)) & 1;
          mTxBusy = (mLen > 1); mTxIrq = 1;
        end else if (rise != 0) begin
          if (mTxBusy != 0) begin
            mTxIdx--; mDt = (mTxSh >> mTxIdx) & 1; mTxBusy = (mTxIdx != 0);
          end else mDt = 0;
        end
        if (rxGo != 0 || (fall != 0 && mRxBusy != 0)) begin
          if (rxGo != 0) begin mRxSh = oldDt; mRxCnt = 1; end
          else begin mRxSh = ((mRxSh << 1) | oldDt) & 16'hFFFF; mRxCnt++; end
          if (mRxCnt == mLen) begin mRxData = mRxSh; mRxIrq = 1; mRxBusy = 0; end
          else mRxBusy = 1;
        end
      end
      if (txWrEn) mTxBuf = int'(txData);
      if (regWrEn) begin
        case (regAddr)
          2'd0: mDiv = int'(regWrData[11:0]);
          2'd1: mFsd = int'(regWrData[11:0]);
          2'd2: mCtrl = int'(regWrData[9:0]);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && (txIrq || rxIrq)) irqSeen++;
    if (rstN && modelOn && !done) begin
      chk("R1 sclkOut", int'(sclkOut), mLvl);
      chk("R2 R4 rfsOut", int'(rfsOut), (((mCtrl >> 4) & (mCtrl >> 8) & mFs) ^ (mCtrl >> 5)) & 1);
      chk("R2 R4 tfsOut", int'(tfsOut), (((mCtrl >> 4) & (mCtrl >> 9) & mFs) ^ (mCtrl >> 6)) & 1);
      chk("R5 dtOut", int'(dtOut), mDt);
      chk("R7 txIrq", int'(txIrq), mTxIrq);
      chk("R7 rxIrq", int'(rxIrq), mRxIrq);
      chk("R8 rxData", int'(rxData), mRxData);
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic loadTx(input logic [15:0] d);
    @(negedge clk); txWrEn = 1; txData = d;
    @(negedge clk); txWrEn = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measurePeriod(output int n);
    int c = 0;
    logic prev = sclkOut;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!prev && sclkOut) break;
      prev = sclkOut;
    end
    prev = sclkOut;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      c++;
      if (!prev && sclkOut) break;
      prev = sclkOut;
    end
    n = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int per;
    logic [7:0] word;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 sclkOut", int'(sclkOut), 0);
    chk("R10 rfsOut", int'(rfsOut), 0);
    chk("R10 tfsOut", int'(tfsOut), 0);
    chk("R10 dtOut", int'(dtOut), 0);
    chk("R10 rxData", int'(rxData), 0);
    chk("R10 irq", int'(txIrq) + int'(rxIrq), 0);
    rstN = 1;
    modelOn = 1;

    // A: div 0, 10-period frames, 8-bit words, loopback
    wrReg(0, 16'd0); wrReg(1, 16'd9); loadTx(16'h00A5);
    wrReg(2, 16'h0397);
    run(400);
    chk("R3 R8 loopback 8b", int'(rxData), 'hA5);

    // B: inverted syncs, 4-bit back-to-back words
    wrReg(2, 16'h0387);
    wrReg(0, 16'd1); wrReg(1, 16'd3); loadTx(16'h0009);
    wrReg(2, 16'h03F3);
    run(300);
    chk("R3 R4 loopback 4b", int'(rxData), 'h9);
    loadTx(16'h0006);
    run(200);
    chk("R3 loopback 4b new", int'(rxData), 'h6);

    // C: 16-bit words, divider 2, then divider reload
    wrReg(2, 16'h03E3);
    wrReg(0, 16'd2); wrReg(1, 16'd20); loadTx(16'h8001);
    wrReg(2, 16'h039F);
    measurePeriod(per);
    chk("R1 period div2", per, 6);
    run(600);
    chk("R3 R8 loopback 16b", int'(rxData), 'h8001);
    wrReg(0, 16'd0);
    run(200);

    // disabled window: no pulses
    wrReg(2, 16'h038F);
    irqSeen = 0;
    run(100);
    chk("R6 no irq when disabled", irqSeen, 0);
    chk("R6 sclk low when disabled", int'(sclkOut), 0);

    // D: 1-bit words
    wrReg(1, 16'd2); loadTx(16'h0001);
    wrReg(2, 16'h0390);
    run(100);
    chk("R3 loopback 1b", int'(rxData), 1);

    // E: external clock and syncs
    wrReg(2, 16'h0380);
    modelOn = 0;
    run(4);
    useLoop = 0;
    loadTx(16'h00C3);
    wrReg(2, 16'h0017);
    word = 8'h5A;
    irqSeen = 0;
    for (int p = 0; p < 10; p++) begin
      @(negedge clk);
      sclkIn = 1;
      rfsIn = (p == 0);
      tfsIn = (p == 0);
      extDr = (p >= 1 && p <= 8) ? word[8-p] : 1'b0;
      run(7);
      if (p >= 1 && p <= 3) chk("R9 R5 ext dtOut", int'(dtOut), int'(8'hC3 >> (8 - p)) & 1);
      @(negedge clk); sclkIn = 0;
      run(7);
    end
    run(4);
    chk("R9 R8 ext rxData", int'(rxData), 'h5A);
    chk("R9 R7 ext irq count", irqSeen, 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule